// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM alive by issuing refresh cycles at a steady rate. A free-running interval timer creates one owed refresh per refresh slot. The block raises a request to the access sequencer and waits for a grant. Once granted, it takes the row strobe, column strobe and write strobe and plays out the refresh waveform. All strobes are active low. Every timing minimum is given in nanoseconds. It is turned into clock cycles at elaboration, and each count is rounded up.

Two refresh styles are available. In column-first refresh, the column strobe falls before the row strobe, so the device uses its own internal row counter. In row-address refresh, the block presents a 12-bit row from its own counter, and only the row strobe pulses. The sequencer may also ask for a hidden refresh. In that case the column strobe stays low from the end of a read, and the row strobe is cycled once more. After reset the block waits out the power-up delay. It then runs eight refreshes on its own, without any handshake, and only then reports the memory ready.

If a request is not granted within a programmable number of cycles, it is moved into a backlog of at most eight missed refreshes. Each granted refresh pays one of them back. A sticky flag records that the backlog overflowed.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, `ras_n`, `cas_n` and `we_n` are 1, `ref_req`, `strobe_own`, `init_done` and `backlog_ovf` are 0, `backlog` is 0 and `row_addr` is 0.
- R2: After reset, the strobes stay idle for the power-up wait. Exactly eight refreshes then follow without any grant, after which `init_done` rises and stays high. `ref_req` is 0 until then.
- R3: In a column-first refresh, `cas_n` is low for at least the cycle count of the column set-up time before `ras_n` falls. It stays low for at least the column hold count after `ras_n` falls.
- R4: `we_n` is 1 at every fall of `ras_n`, so the device never enters test mode.
- R5: `ras_n` stays low for at least the active-time count. It stays high for at least the precharge count before each fall. Successive falls are at least the cycle-time count apart.
- R6: With `ras_only_mode`=1, `cas_n` stays 1 for the whole refresh and `row_addr` holds the counter value. The counter advances by one after each such refresh and wraps from 4095 to 0. Column-first and hidden refreshes leave it unchanged.
- R7: `ref_req` is 1 only when a refresh is owed, the block is idle and `init_done` is 1. When `ref_req` and `ref_gnt` are both 1 at a clock edge, the refresh starts at that edge: `strobe_own` becomes 1 and `ref_req` becomes 0, and `strobe_own` stays 1 until precharge ends.
- R8: After init, one refresh becomes owed every interval. With the grant always given, one refresh runs per interval and `backlog` stays 0.
- R9: An owed refresh that is not granted within `gnt_budget` cycles, or that is overtaken by the next interval, adds one to `backlog`. `backlog` saturates at 8. A further miss sets `backlog_ovf`, which stays 1 until reset.
- R10: Granted refreshes empty the backlog, one entry per refresh, until it reaches 0.
- R11: If `hidden_req` is 1 at the grant, `cas_n` is low from the first refresh cycle until `ras_n` rises. `ras_n` is high for the precharge count, then low for the active-time count, and then both strobes return high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ras_only_mode | input | 1 | 1 = row-address refresh, 0 = column-first refresh |
| hidden_req | input | 1 | Sequencer asks for a hidden refresh at this grant |
| ref_gnt | input | 1 | Grant from the access sequencer |
| gnt_budget | input | 8 | Cycles a request may wait before it counts as missed |
| ref_req | output | 1 | Refresh request to the sequencer |
| strobe_own | output | 1 | Block is driving the strobes and the row address |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write strobe, held high |
| row_addr | output | 12 | Row for row-address refresh |
| init_done | output | 1 | Power-up sequence complete |
| backlog | output | 4 | Number of missed refreshes |
| backlog_ovf | output | 1 | Sticky backlog overflow |

## Verification
The hardest state to reach is the 4095-to-0 wrap of the row counter. Reaching it takes more than four thousand row-address refreshes, counting the eight issued during init. The bench shortens the refresh interval and the power-up wait through parameters, holds the grant high, and tracks the expected row at every row-strobe fall until it sees the wrap. Backlog overflow is reached by withholding the grant with a two-cycle budget across nine intervals, sampling the backlog in the middle of each interval.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

   typedef enum logic [2:0] {
      ST_BOOT,
      ST_IDLE,
      ST_LEAD,
      ST_ACT,
      ST_PRE
   } seq_state_t;

   typedef enum logic [1:0] {
      KIND_CBR,
      KIND_ROWONLY,
      KIND_HIDDEN
   } ref_kind_t;

   function automatic int ns_to_cycles(input int ns, input int clk_ns);
      int c;
      c = (ns + clk_ns - 1) / clk_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
   parameter int INIT_WAIT = 10000,
   parameter int INTERVAL  = 780
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic boot_over,
   output logic tick
);
   localparam int BW = $clog2(INIT_WAIT + 1);
   localparam int IW = $clog2(INTERVAL + 1);

   logic [BW-1:0] boot_cnt;
   logic [IW-1:0] ivl_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot_cnt  <= '0;
         boot_over <= 1'b0;
      end else if (!boot_over) begin
         if (boot_cnt == BW'(INIT_WAIT - 1)) boot_over <= 1'b1;
         else                                boot_cnt  <= boot_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ivl_cnt <= '0;
      else if (!run)                       ivl_cnt <= '0;
      else if (ivl_cnt == IW'(INTERVAL-1)) ivl_cnt <= '0;
      else                                 ivl_cnt <= ivl_cnt + 1'b1;
   end

   assign tick = run && (ivl_cnt == IW'(INTERVAL - 1));

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R8

endmodule

// File: rtl/refsched_backlog.sv
module refsched_backlog #(
   parameter int MAX_BACKLOG = 8,
   parameter int BUDGET_W    = 8,
   parameter int BL_W        = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                take,
   input  logic [BUDGET_W-1:0] budget,
   output logic                owed,
   output logic [BL_W-1:0]     backlog,
   output logic                ovf
);
   logic                live;
   logic [BUDGET_W-1:0] wait_cnt;
   logic                expire;
   logic                miss;
   logic                consume_pend;

   assign expire       = live && (wait_cnt >= budget);
   assign miss         = live && !take && (expire || tick);
   assign consume_pend = take && !live;
   assign owed         = live || (backlog != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live     <= 1'b0;
         wait_cnt <= '0;
      end else if (tick) begin
         live     <= 1'b1;
         wait_cnt <= '0;
      end else if ((take && live) || expire) begin
         live     <= 1'b0;
      end else if (live) begin
         wait_cnt <= wait_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         backlog <= '0;
         ovf     <= 1'b0;
      end else if (miss) begin
         if (backlog == BL_W'(MAX_BACKLOG)) ovf     <= 1'b1;
         else                               backlog <= backlog + 1'b1;
      end else if (consume_pend && backlog != '0) begin
         backlog <= backlog - 1'b1;
      end
   end

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf); // R9
   AST_BACKLOG_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      backlog <= BL_W'(MAX_BACKLOG)); // R9
   AST_BACKLOG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (backlog == $past(backlog)) || (backlog == $past(backlog) + 1'b1)
      || (backlog == $past(backlog) - 1'b1)); // R10

endmodule

// File: rtl/refsched_seq.sv
module refsched_seq
   import refsched_pkg::*;
#(
   parameter int ROW_W     = 12,
   parameter int INIT_REFS = 8,
   parameter int L_CBR     = 1,
   parameter int L_ROW     = 1,
   parameter int L_HID     = 2,
   parameter int T_ACT     = 3,
   parameter int T_CHR     = 1,
   parameter int T_PRE     = 2,
   parameter int HIDDEN_EN = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boot_over,
   input  logic             owed,
   input  logic             gnt,
   input  logic             hidden_req,
   input  logic             ras_only_mode,
   output logic             ref_req,
   output logic             take,
   output logic             init_done,
   output logic             own,
   output logic             ras_n,
   output logic             cas_n,
   output logic             we_n,
   output logic [ROW_W-1:0] row_addr
);
   localparam int LMAX  = max2(max2(max2(L_CBR, L_ROW), max2(L_HID, T_ACT)), T_PRE);
   localparam int CNT_W = $clog2(LMAX + 1);
   localparam int IR_W  = $clog2(INIT_REFS + 1);

   seq_state_t       state;
   ref_kind_t        kind;
   ref_kind_t        base_kind;
   ref_kind_t        sel_kind;
   logic [CNT_W-1:0] cnt;
   logic [IR_W-1:0]  init_left;
   logic [ROW_W-1:0] row;
   logic             hid_sel;
   logic             cas_low;

   generate
      if (HIDDEN_EN != 0) begin : g_hidden
         assign hid_sel = hidden_req;
      end else begin : g_no_hidden
         logic unused_hidden;
         assign unused_hidden = hidden_req;
         assign hid_sel       = 1'b0;
      end
   endgenerate

   function automatic logic [CNT_W-1:0] lead_of(input ref_kind_t k);
      case (k)
         KIND_HIDDEN:  return CNT_W'(L_HID - 1);
         KIND_ROWONLY: return CNT_W'(L_ROW - 1);
         default:      return CNT_W'(L_CBR - 1);
      endcase
   endfunction

   assign base_kind = ras_only_mode ? KIND_ROWONLY : KIND_CBR;
   assign sel_kind  = hid_sel ? KIND_HIDDEN : base_kind;
   assign ref_req   = init_done && owed && (state == ST_IDLE);
   assign take      = ref_req && gnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_BOOT;
         kind      <= KIND_CBR;
         cnt       <= '0;
         init_left <= IR_W'(INIT_REFS);
         init_done <= 1'b0;
         row       <= '0;
      end else begin
         case (state)
            ST_BOOT: if (boot_over) begin
               state <= ST_LEAD;
               kind  <= base_kind;
               cnt   <= lead_of(base_kind);
            end
            ST_IDLE: if (take) begin
               state <= ST_LEAD;
               kind  <= sel_kind;
               cnt   <= lead_of(sel_kind);
            end
            ST_LEAD: if (cnt == '0) begin
               state <= ST_ACT;
               cnt   <= CNT_W'(T_ACT - 1);
            end else cnt <= cnt - 1'b1;
            ST_ACT: if (cnt == '0) begin
               state <= ST_PRE;
               cnt   <= CNT_W'(T_PRE - 1);
            end else cnt <= cnt - 1'b1;
            ST_PRE: if (cnt == '0) begin
               if (kind == KIND_ROWONLY) row <= row + 1'b1;
               if (init_done) begin
                  state <= ST_IDLE;
               end else if (init_left == IR_W'(1)) begin
                  init_left <= '0;
                  init_done <= 1'b1;
                  state     <= ST_IDLE;
               end else begin
                  init_left <= init_left - 1'b1;
                  state     <= ST_LEAD;
                  kind      <= base_kind;
                  cnt       <= lead_of(base_kind);
               end
            end else cnt <= cnt - 1'b1;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      cas_low = 1'b0;
      if (state == ST_LEAD) cas_low = (kind != KIND_ROWONLY);
      else if (state == ST_ACT)
         cas_low = (kind == KIND_HIDDEN) ||
                   ((kind == KIND_CBR) && (cnt >= CNT_W'(T_ACT - T_CHR)));
   end

   assign own      = (state == ST_LEAD) || (state == ST_ACT) || (state == ST_PRE);
   assign ras_n    = (state != ST_ACT);
   assign cas_n    = !cas_low;
   assign we_n     = 1'b1;
   assign row_addr = row;

   AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n) && !cas_n) |-> $past(!cas_n)); // R3
   AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n && cas_n && $past(!ras_n)) |-> $stable(row_addr)); // R6
   AST_GRANT_START: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req && gnt) |=> (own && !ref_req)); // R7
   AST_INIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done); // R2

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
   import refsched_pkg::*;
#(
   parameter int CLK_NS      = 20,
   parameter int INTERVAL_NS = 15600,
   parameter int INIT_NS     = 200000,
   parameter int TCSR_NS     = 5,
   parameter int TCHR_NS     = 10,
   parameter int TASR_NS     = 0,
   parameter int TRAS_NS     = 50,
   parameter int TRP_NS      = 30,
   parameter int TRC_NS      = 84,
   parameter int ROW_W       = 12,
   parameter int INIT_REFS   = 8,
   parameter int MAX_BACKLOG = 8,
   parameter int BUDGET_W    = 8,
   parameter int HIDDEN_EN   = 1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 ras_only_mode,
   input  logic                                 hidden_req,
   input  logic                                 ref_gnt,
   input  logic [BUDGET_W-1:0]                  gnt_budget,
   output logic                                 ref_req,
   output logic                                 strobe_own,
   output logic                                 ras_n,
   output logic                                 cas_n,
   output logic                                 we_n,
   output logic [ROW_W-1:0]                     row_addr,
   output logic                                 init_done,
   output logic [$clog2(MAX_BACKLOG+1)-1:0]     backlog,
   output logic                                 backlog_ovf
);
   localparam int BL_W   = $clog2(MAX_BACKLOG + 1);
   localparam int C_IVL  = ns_to_cycles(INTERVAL_NS, CLK_NS);
   localparam int C_INIT = ns_to_cycles(INIT_NS, CLK_NS);
   localparam int C_CSR  = ns_to_cycles(TCSR_NS, CLK_NS);
   localparam int C_CHR  = ns_to_cycles(TCHR_NS, CLK_NS);
   localparam int C_ASR  = ns_to_cycles(TASR_NS, CLK_NS);
   localparam int C_RAS  = ns_to_cycles(TRAS_NS, CLK_NS);
   localparam int C_RP   = ns_to_cycles(TRP_NS, CLK_NS);
   localparam int C_RC   = ns_to_cycles(TRC_NS, CLK_NS);
   localparam int C_PRE  = max2(C_RP, C_RC - C_RAS - 1);

   generate
      if (C_CHR > C_RAS) begin : g_bad_chr
         $error("column hold exceeds row active time");
      end
      if (C_IVL < 2) begin : g_bad_ivl
         $error("refresh interval must span two cycles");
      end
      if (ROW_W < 1 || INIT_REFS < 1 || MAX_BACKLOG < 1) begin : g_bad_size
         $error("row width, init count and backlog depth must be positive");
      end
   endgenerate

   logic boot_over;
   logic tick;
   logic owed;
   logic take;

   refsched_timer #(
      .INIT_WAIT (C_INIT),
      .INTERVAL  (C_IVL)
   ) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (init_done),
      .boot_over (boot_over),
      .tick      (tick)
   );

   refsched_backlog #(
      .MAX_BACKLOG (MAX_BACKLOG),
      .BUDGET_W    (BUDGET_W),
      .BL_W        (BL_W)
   ) i_backlog (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .take    (take),
      .budget  (gnt_budget),
      .owed    (owed),
      .backlog (backlog),
      .ovf     (backlog_ovf)
   );

   refsched_seq #(
      .ROW_W     (ROW_W),
      .INIT_REFS (INIT_REFS),
      .L_CBR     (C_CSR),
      .L_ROW     (C_ASR),
      .L_HID     (C_RP),
      .T_ACT     (C_RAS),
      .T_CHR     (C_CHR),
      .T_PRE     (C_PRE),
      .HIDDEN_EN (HIDDEN_EN)
   ) i_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .boot_over     (boot_over),
      .owed          (owed),
      .gnt           (ref_gnt),
      .hidden_req    (hidden_req),
      .ras_only_mode (ras_only_mode),
      .ref_req       (ref_req),
      .take          (take),
      .init_done     (init_done),
      .own           (strobe_own),
      .ras_n         (ras_n),
      .cas_n         (cas_n),
      .we_n          (we_n),
      .row_addr      (row_addr)
   );

endmodule

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
   localparam int CLK_NS = 20;
   localparam int IVL    = 12;
   localparam int INITW  = 30;
   localparam int T_CSR  = 1;
   localparam int T_CHR  = 1;
   localparam int T_ASR  = 1;
   localparam int T_RAS  = 3;
   localparam int T_RP   = 2;
   localparam int T_RC   = 5;
   localparam int T_PRE  = (T_RP > T_RC - T_RAS - 1) ? T_RP : (T_RC - T_RAS - 1);
   localparam int ROWS   = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ras_only_mode = 1'b0;
   logic hidden_req = 1'b0;
   logic ref_gnt = 1'b0;
   logic [7:0] gnt_budget = 8'd255;
   logic ref_req, strobe_own, ras_n, cas_n, we_n, init_done, backlog_ovf;
   logic [11:0] row_addr;
   logic [3:0] backlog;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done_flag = 0;

   always #(CLK_NS/2) clk = ~clk;

   dram_refresh_sched #(
      .CLK_NS(CLK_NS), .INTERVAL_NS(IVL*CLK_NS), .INIT_NS(INITW*CLK_NS)
   ) i_dram_refresh_sched (
      .clk(clk), .rst_n(rst_n), .ras_only_mode(ras_only_mode),
      .hidden_req(hidden_req), .ref_gnt(ref_gnt), .gnt_budget(gnt_budget),
      .ref_req(ref_req), .strobe_own(strobe_own), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .row_addr(row_addr), .init_done(init_done),
      .backlog(backlog), .backlog_ovf(backlog_ovf)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // waveform monitor: timing rules checked at every row-strobe fall and rise
   bit prev_ras = 1;
   bit first_fall = 1;
   int since_fall = 0, high_run = 0, low_run = 0, cas_run = 0;
   bit chr_open = 0;
   int chr_cnt = 0;
   int falls = 0;
   int rowonly_cnt = 0;
   int exp_row = 0;
   bit saw_top = 0, wrap_seen = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         prev_ras = 1; first_fall = 1; since_fall = 0; high_run = 0;
         low_run = 0; cas_run = 0; chr_open = 0; chr_cnt = 0;
         exp_row = 0; rowonly_cnt = 0; saw_top = 0; wrap_seen = 0;
      end else begin
         since_fall++;
         if (ref_req && strobe_own) chk(0, "R7 req while owning", 1, 0);
         if (prev_ras && !ras_n) begin
            chk(we_n == 1'b1, "R4 we_n at ras fall", we_n, 1);
            if (!first_fall) begin
               chk(high_run >= T_RP, "R5 precharge width", high_run, T_RP);
               chk(since_fall >= T_RC, "R5 cycle time", since_fall, T_RC);
            end
            if (!cas_n) begin
               chk(cas_run >= T_CSR, "R3 cas setup", cas_run, T_CSR);
               chr_open = 1; chr_cnt = 0;
            end else if (ras_only_mode) begin
               chk(row_addr == exp_row[11:0], "R6 row address", row_addr, exp_row);
               if (saw_top && row_addr == 12'd0) wrap_seen = 1;
               saw_top = (row_addr == 12'd4095);
               exp_row = (exp_row + 1) % ROWS;
               rowonly_cnt++;
            end
            falls++; first_fall = 0; since_fall = 0;
         end
         if (!prev_ras && ras_n)
            chk(low_run >= T_RAS, "R5 active width", low_run, T_RAS);
         if (chr_open) begin
            if (cas_n || ras_n) begin
               chk(chr_cnt >= T_CHR, "R3 cas hold", chr_cnt, T_CHR);
               chr_open = 0;
            end else chr_cnt++;
         end
         low_run  = ras_n ? 0 : low_run + 1;
         high_run = ras_n ? high_run + 1 : 0;
         cas_run  = cas_n ? 0 : cas_run + 1;
         prev_ras = ras_n;
      end
   end

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   task automatic do_reset(input bit rowonly);
      @(negedge clk);
      rst_n = 0; ref_gnt = 0; hidden_req = 0; gnt_budget = 8'd255;
      ras_only_mode = rowonly;
      repeat (3) @(negedge clk);
      chk(ras_n && cas_n && we_n, "R1 strobes idle", {ras_n, cas_n, we_n}, 7);
      chk(!ref_req && !strobe_own && !init_done, "R1 control low",
          {ref_req, strobe_own, init_done}, 0);
      chk(backlog == 0 && !backlog_ovf, "R1 backlog clear", backlog, 0);
      chk(row_addr == 0, "R1 row zero", row_addr, 0);
      rst_n = 1;
   endtask

   task automatic wait_init();
      for (int i = 0; i < 400 && !init_done; i++) @(negedge clk);
   endtask

   task automatic t_init(input bit rowonly);
      int f0;
      bit quiet;
      do_reset(rowonly);
      quiet = 1;
      for (int i = 0; i < INITW - 1; i++) begin
         @(negedge clk);
         if (strobe_own || !ras_n || !cas_n) quiet = 0;
      end
      chk(quiet, "R2 power-up wait quiet", !quiet, 0);
      f0 = falls;
      for (int i = 0; i < 400 && !init_done; i++) begin
         @(negedge clk);
         if (!init_done && ref_req) chk(0, "R2 request during init", 1, 0);
      end
      chk(init_done, "R2 init completes", init_done, 1);
      chk(falls - f0 == 8, "R2 eight init refreshes", falls - f0, 8);
      if (rowonly) chk(row_addr == 8, "R6 row after init", row_addr, 8);
      repeat (3) @(negedge clk);
      chk(init_done, "R2 init stays done", init_done, 1);
   endtask

   task automatic t_single(input bit hid);
      int r0, lead;
      bit rowonly;
      rowonly = ras_only_mode && !hid;
      for (int i = 0; i < 200 && !ref_req; i++) @(negedge clk);
      chk(ref_req && !strobe_own, "R7 request raised while idle", ref_req, 1);
      r0 = row_addr;
      ref_gnt = 1; hidden_req = hid;
      lead = hid ? T_RP : (rowonly ? T_ASR : T_CSR);
      @(negedge clk);
      ref_gnt = 0; hidden_req = 0;
      chk(strobe_own && !ref_req, "R7 grant starts refresh", {strobe_own, ref_req}, 2);
      for (int i = 0; i < lead; i++) begin
         if (i > 0) @(negedge clk);
         chk(ras_n == 1, hid ? "R11 lead ras high" : "R3 lead ras high", ras_n, 1);
         chk(cas_n == rowonly, hid ? "R11 lead cas low" : "R6 lead cas", cas_n, rowonly);
      end
      for (int i = 0; i < T_RAS; i++) begin
         bit ec;
         @(negedge clk);
         ec = hid ? 1'b0 : (rowonly ? 1'b1 : (i >= T_CHR));
         chk(ras_n == 0, hid ? "R11 ras low" : "R5 ras low", ras_n, 0);
         chk(cas_n == ec, hid ? "R11 cas during active" : "R3 cas during active", cas_n, ec);
      end
      for (int i = 0; i < T_PRE; i++) begin
         @(negedge clk);
         chk(ras_n && cas_n && strobe_own, "R11 precharge strobes",
             {ras_n, cas_n, strobe_own}, 7);
      end
      @(negedge clk);
      chk(!strobe_own, "R7 strobes released", strobe_own, 0);
      chk(row_addr == (rowonly ? (r0 + 1) % ROWS : r0), "R6 row step",
          row_addr, rowonly ? (r0 + 1) % ROWS : r0);
   endtask

   task automatic t_steady(input bit rowonly);
      int f0;
      bit bl_ok;
      do_reset(rowonly);
      wait_init();
      ref_gnt = 1;
      repeat (IVL * 2) @(negedge clk);
      f0 = falls; bl_ok = 1;
      for (int i = 0; i < IVL * 10; i++) begin
         @(negedge clk);
         if (backlog != 0) bl_ok = 0;
      end
      chk(falls - f0 >= 9 && falls - f0 <= 11, "R8 one refresh per interval", falls - f0, 10);
      chk(bl_ok, "R8 backlog stays empty", !bl_ok, 0);
      ref_gnt = 0;
   endtask

   task automatic t_overflow();
      int f0;
      do_reset(0);
      gnt_budget = 8'd2;
      wait_init();
      repeat (IVL + 6) @(negedge clk);
      chk(backlog == 1 && !backlog_ovf, "R9 first miss", backlog, 1);
      repeat (IVL * 7) @(negedge clk);
      chk(backlog == 8 && !backlog_ovf, "R9 backlog full", backlog, 8);
      repeat (IVL) @(negedge clk);
      chk(backlog == 8, "R9 backlog saturates", backlog, 8);
      chk(backlog_ovf, "R9 overflow flagged", backlog_ovf, 1);
      f0 = falls;
      ref_gnt = 1;
      for (int i = 0; i < 400 && backlog != 0; i++) @(negedge clk);
      chk(backlog == 0, "R10 backlog drained", backlog, 0);
      chk(falls - f0 >= 8, "R10 one entry per refresh", falls - f0, 8);
      chk(backlog_ovf, "R9 overflow sticky", backlog_ovf, 1);
      ref_gnt = 0;
   endtask

   task automatic t_wrap();
      do_reset(1);
      ref_gnt = 1;
      for (int i = 0; i < 70000 && rowonly_cnt < 4100; i++) @(negedge clk);
      ref_gnt = 0;
      repeat (10) @(negedge clk);
      chk(wrap_seen, "R6 row wraps 4095 to 0", wrap_seen, 1);
      chk(row_addr == exp_row[11:0], "R6 row after wrap", row_addr, exp_row);
   endtask

   initial begin
      t_init(0);
      t_single(0);
      t_single(1);
      t_init(1);
      t_single(0);
      t_single(1);
      t_steady(0);
      t_steady(1);
      t_overflow();
      t_wrap();
      finish_run();
   end

endmodule